// File: doc/BRIEF.md
# Reset Event Classifier and Sequencer

This block turns the reset requests arriving at a chip into one clean internal reset. Its inputs are an active-low external reset pin, a level input that selects how that pin is handled, a software reset strobe and a watchdog overflow strobe. It works out which kind of reset happened, runs a fixed internal reset sequence of 512 clocks and records the kind in five status flags. When the level input is high, an external pulse goes through a two-flop synchronizer and its width is measured in clocks. A pulse at or below a floor is dropped as a glitch. A wider pulse is sorted as short or long. Before the reset takes hold, a drain window of six clocks lets accesses in flight complete. When the level input is low, the pin forces the internal reset in the same cycle and cancels whatever sequence is running.

At the end of every sequence caused by the pin or by power-on, a one-cycle strobe latches a 16-bit startup configuration word. A short pin reset keeps the three clock-select bits [15:13] and takes only the other bits. If enabled, an open-drain pull-down drives the reset pin low for the length of the sequence, so that other devices on the board are reset as well.

Top module: `rst_event_seq`

## Requirements
- R1: While `rst` is high, `int_rst` is 1 and `rst_flags` is 5'b00001. After `rst` falls, `int_rst` stays high and drops on the 512th clock edge. In that cycle `cfg_stb` pulses and `cfg_q` takes the whole of `cfg_in`.
- R2: With `mode_lvl` high, `ext_rst_n` passes through two synchronizer flops. A low pulse of L clocks with L > MIN_W = max(2, FLOOR_CYC) raises `drain_req` MIN_W+3 clock edges after the pin falls. A pulse with L <= MIN_W is ignored: no `drain_req`, no `int_rst`, and no change to `rst_flags` or `cfg_q`.
- R3: `drain_req` stays high for 6 cycles while `int_rst` is 0. `int_rst` rises in the cycle after `drain_req` falls.
- R4: The internal reset lasts 512 cycles. If the synchronized pin is still low when those cycles end, `int_rst` holds until the release is seen and falls 3 clock edges after the pin rises.
- R5: A pin reset with L > LONG_W = 522 + MIN_W is long and sets `rst_flags` to 5'b00010. A pin reset with MIN_W < L <= LONG_W is short and sets 5'b00100. The flags change when `int_rst` falls.
- R6: At the end of a long pin reset, `cfg_q` takes all of `cfg_in`. At the end of a short one, `cfg_q[15:13]` keep their old values and bits [12:0] come from `cfg_in`. `cfg_stb` is a single-cycle pulse in the cycle `int_rst` falls, and it pulses only after pin, async and power-on resets.
- R7: A `sw_rst` strobe sets `rst_flags` to 5'b10000 and a `wdt_ovf` strobe sets 5'b01000. Each runs a 512-cycle sequence and leaves `cfg_q` unchanged. If both arrive in one cycle, only the watchdog flag is set. Strobes are ignored while a sequence runs.
- R8: `pin_pd_en` is high only when `bidir_en` is 1, and only during the 512 sequence cycles. It is on for pin and async resets. For software and watchdog resets it is on only if `mode_lvl` is high. It is off during the hold of R4.
- R9: When `ext_rst_n` and `mode_lvl` are both low, `int_rst` is 1 in the same cycle, with no clock edge needed. An async reset aborts any sequence in progress, with `pin_pd_en` off while the pin is held. After the synchronized pin is released, a 512-cycle sequence runs, then `rst_flags` become 5'b00001 and `cfg_q` takes all of `cfg_in`.
- R10: Exactly one bit of `rst_flags` is set at all times. Each completed sequence replaces the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | External reset pin level, active low |
| mode_lvl | input | 1 | Reset handling level: 0 async, 1 synchronous |
| sw_rst | input | 1 | Software reset strobe |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| bidir_en | input | 1 | Enables the pull-down on the reset pin |
| cfg_in | input | 16 | Startup configuration word |
| int_rst | output | 1 | Internal reset |
| pin_pd_en | output | 1 | Open-drain pull-down enable for the reset pin |
| drain_req | output | 1 | Drain window: finish pending accesses |
| cfg_stb | output | 1 | One-cycle configuration latch strobe |
| cfg_q | output | 16 | Latched configuration word |
| rst_flags | output | 5 | {sw, watchdog, short pin, long pin, power-on} |

## Verification
The watchdog strobe and the software strobe can arrive in the same clock cycle. The bench drives both high on one falling edge. It passes if exactly one 512-cycle sequence runs and the flags end up showing only the watchdog bit. An async pin assertion can also arrive while a software sequence is running. The bench provokes this 20 cycles into a sequence and checks three things: the pull-down drops, a new full-length sequence follows the release, and the flags end up as power-on instead of software.

// File: rtl/rst_event_pkg.sv
`timescale 1ns/1ps
package rst_event_pkg;

    // two clocks per four half-periods; (1032 + 12) half-periods in clocks
    localparam int TCL4_CYC      = 2;
    localparam int LONG_BASE_CYC = (1032 + 12) / 2;

    typedef enum logic [2:0] {
        K_PON, K_HW, K_WDT, K_SW, K_ASY
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_DRAIN, S_SEQ, S_HOLD, S_ABORT
    } state_t;

    typedef struct packed {
        logic sw;
        logic wdt;
        logic hw_short;
        logic hw_long;
        logic pon;
    } flags_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic flags_t flags_for(input kind_t k, input logic is_long);
        flags_t f;
        f = '0;
        unique case (k)
            K_HW:    if (is_long) f.hw_long = 1'b1; else f.hw_short = 1'b1;
            K_WDT:   f.wdt = 1'b1;
            K_SW:    f.sw  = 1'b1;
            default: f.pon = 1'b1;
        endcase
        return f;
    endfunction

    function automatic logic latches_cfg(input kind_t k);
        return (k == K_HW) || (k == K_PON) || (k == K_ASY);
    endfunction

endpackage

// File: rtl/rev_sync2.sv
`timescale 1ns/1ps
module rev_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/rev_width_meter.sv
`timescale 1ns/1ps
module rev_width_meter #(
    parameter int MIN_W  = 100,
    parameter int LONG_W = 622
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_lo,
    output logic qual,
    output logic long_hit
);
    localparam int SAT = LONG_W + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)              run <= '0;
        else if (!pin_lo)     run <= '0;
        else if (run != CW'(SAT)) run <= run + 1'b1;
    end

    // this cycle is low cycle number run+1
    assign qual     = pin_lo && (run == CW'(MIN_W));
    assign long_hit = pin_lo && (run == CW'(LONG_W));
endmodule

// File: rtl/rev_seq_fsm.sv
`timescale 1ns/1ps
module rev_seq_fsm
    import rst_event_pkg::*;
#(
    parameter int CFG_W     = 16,
    parameter int CLKSEL_W  = 3,
    parameter int DRAIN_CYC = 6,
    parameter int SEQ_CYC   = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_lo,
    input  logic             async_now,
    input  logic             mode_lvl,
    input  logic             sw_rst,
    input  logic             wdt_ovf,
    input  logic             bidir_en,
    input  logic             qual,
    input  logic             long_hit,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             int_rst,
    output logic             pin_pd_en,
    output logic             drain_req,
    output logic             cfg_stb,
    output logic [CFG_W-1:0] cfg_q,
    output flags_t           flags
);
    localparam int CNT_W = $clog2(max_int(SEQ_CYC, DRAIN_CYC));
    localparam logic [CNT_W-1:0] SEQ_LAST   = CNT_W'(SEQ_CYC - 1);
    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYC - 1);

    state_t           state;
    kind_t            kind;
    logic [CNT_W-1:0] cnt;
    logic             long_q;
    logic [CFG_W-1:0] cfg_next;
    logic             full_cfg;

    assign full_cfg = (kind != K_HW) || long_q;

    generate
        if (CLKSEL_W == 0) begin : g_nokeep
            assign cfg_next = cfg_in;
        end else begin : g_keep
            assign cfg_next = full_cfg ? cfg_in
                            : {cfg_q[CFG_W-1 -: CLKSEL_W], cfg_in[CFG_W-CLKSEL_W-1:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_SEQ;
            kind    <= K_PON;
            cnt     <= '0;
            long_q  <= 1'b0;
            flags   <= flags_for(K_PON, 1'b0);
            cfg_q   <= '0;
            cfg_stb <= 1'b0;
        end else begin
            cfg_stb <= 1'b0;
            if (pin_lo && !mode_lvl && state != S_ABORT) begin
                state <= S_ABORT;
                cnt   <= '0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (qual && mode_lvl) begin
                            kind   <= K_HW;
                            long_q <= 1'b0;
                            state  <= S_DRAIN;
                            cnt    <= '0;
                        end else if (wdt_ovf) begin
                            kind  <= K_WDT;
                            state <= S_SEQ;
                            cnt   <= '0;
                        end else if (sw_rst) begin
                            kind  <= K_SW;
                            state <= S_SEQ;
                            cnt   <= '0;
                        end
                    end
                    S_DRAIN: begin
                        if (long_hit) long_q <= 1'b1;
                        if (cnt == DRAIN_LAST) begin
                            state <= S_SEQ;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_SEQ: begin
                        if (long_hit) long_q <= 1'b1;
                        if (cnt != SEQ_LAST) begin
                            cnt <= cnt + 1'b1;
                        end else if (kind == K_HW && pin_lo) begin
                            state <= S_HOLD;
                        end else begin
                            state <= S_IDLE;
                            flags <= flags_for(kind, long_q);
                            if (latches_cfg(kind)) begin
                                cfg_stb <= 1'b1;
                                cfg_q   <= cfg_next;
                            end
                        end
                    end
                    S_HOLD: begin
                        if (long_hit) long_q <= 1'b1;
                        if (!pin_lo) begin
                            state   <= S_IDLE;
                            flags   <= flags_for(kind, long_q);
                            cfg_stb <= 1'b1;
                            cfg_q   <= cfg_next;
                        end
                    end
                    S_ABORT: begin
                        if (!pin_lo) begin
                            kind  <= K_ASY;
                            state <= S_SEQ;
                            cnt   <= '0;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        int_rst   = rst || async_now || (state == S_SEQ) || (state == S_HOLD)
                    || (state == S_ABORT);
        drain_req = (state == S_DRAIN);
        pin_pd_en = (state == S_SEQ) && bidir_en
                    && ((kind == K_HW) || (kind == K_ASY)
                        || (mode_lvl && ((kind == K_SW) || (kind == K_WDT))));
    end
endmodule

// File: rtl/rst_event_seq.sv
`timescale 1ns/1ps
module rst_event_seq
    import rst_event_pkg::*;
#(
    parameter int CFG_W       = 16,
    parameter int CLKSEL_W    = 3,
    parameter int FLOOR_CYC   = 100,
    parameter int DRAIN_CYC   = 6,
    parameter int SEQ_CYC     = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rst_n,
    input  logic             mode_lvl,
    input  logic             sw_rst,
    input  logic             wdt_ovf,
    input  logic             bidir_en,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             int_rst,
    output logic             pin_pd_en,
    output logic             drain_req,
    output logic             cfg_stb,
    output logic [CFG_W-1:0] cfg_q,
    output logic [4:0]       rst_flags
);
    localparam int MIN_W  = max_int(TCL4_CYC, FLOOR_CYC);
    localparam int LONG_W = LONG_BASE_CYC + MIN_W;

    logic   pin_sync;
    logic   pin_lo;
    logic   qual;
    logic   long_hit;
    logic   async_now;
    flags_t flags;

    assign async_now = !ext_rst_n && !mode_lvl;
    assign pin_lo    = !pin_sync;
    assign rst_flags = flags;

    rev_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_rst_n),
        .q   (pin_sync)
    );

    rev_width_meter #(.MIN_W(MIN_W), .LONG_W(LONG_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .pin_lo   (pin_lo),
        .qual     (qual),
        .long_hit (long_hit)
    );

    rev_seq_fsm #(
        .CFG_W     (CFG_W),
        .CLKSEL_W  (CLKSEL_W),
        .DRAIN_CYC (DRAIN_CYC),
        .SEQ_CYC   (SEQ_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pin_lo    (pin_lo),
        .async_now (async_now),
        .mode_lvl  (mode_lvl),
        .sw_rst    (sw_rst),
        .wdt_ovf   (wdt_ovf),
        .bidir_en  (bidir_en),
        .qual      (qual),
        .long_hit  (long_hit),
        .cfg_in    (cfg_in),
        .int_rst   (int_rst),
        .pin_pd_en (pin_pd_en),
        .drain_req (drain_req),
        .cfg_stb   (cfg_stb),
        .cfg_q     (cfg_q),
        .flags     (flags)
    );
endmodule

// File: rtl/rst_event_chk.sv
`timescale 1ns/1ps
module rst_event_chk #(
    parameter int CFG_W    = 16,
    parameter int CLKSEL_W = 3,
    parameter int SEQ_CYC  = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_rst_n,
    input logic             mode_lvl,
    input logic             bidir_en,
    input logic             int_rst,
    input logic             pin_pd_en,
    input logic             drain_req,
    input logic             cfg_stb,
    input logic [CFG_W-1:0] cfg_q,
    input logic [4:0]       rst_flags
);
    localparam int PW = $clog2(SEQ_CYC + 2);
    logic [PW-1:0] pd_run;

    always_ff @(posedge clk) begin
        if (rst)            pd_run <= '0;
        else if (pin_pd_en) pd_run <= (pd_run == PW'(SEQ_CYC + 1)) ? pd_run : pd_run + 1'b1;
        else                pd_run <= '0;
    end

    // R9
    async_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_rst_n && !mode_lvl) |-> int_rst);

    // R10
    flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rst_flags) == 1);

    // R3
    drain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_req && mode_lvl) |-> !int_rst);

    // R6
    cfg_stb_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_stb |-> ($past(int_rst) && !int_rst));

    // R6
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_stb |=> !cfg_stb);

    generate
        if (CLKSEL_W > 0) begin : g_keep
            // R6
            short_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (cfg_stb && rst_flags[2]) |->
                    (cfg_q[CFG_W-1 -: CLKSEL_W] == $past(cfg_q[CFG_W-1 -: CLKSEL_W])));
        end
    endgenerate

    // R8
    pd_bidir_chk: assert property (@(posedge clk) disable iff (rst)
        pin_pd_en |-> (bidir_en && int_rst));

    // R8
    pd_len_chk: assert property (@(posedge clk) disable iff (rst)
        pd_run <= PW'(SEQ_CYC));
endmodule

bind rst_event_seq rst_event_chk #(
    .CFG_W    (CFG_W),
    .CLKSEL_W (CLKSEL_W),
    .SEQ_CYC  (SEQ_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_rst_n (ext_rst_n),
    .mode_lvl  (mode_lvl),
    .bidir_en  (bidir_en),
    .int_rst   (int_rst),
    .pin_pd_en (pin_pd_en),
    .drain_req (drain_req),
    .cfg_stb   (cfg_stb),
    .cfg_q     (cfg_q),
    .rst_flags (rst_flags)
);

// File: tb/sim_rst_event_seq.sv
`timescale 1ns/1ps
module sim_rst_event_seq;
    localparam int MIN_W   = 100;
    localparam int LONG_W  = 522 + MIN_W;
    localparam int SEQ     = 512;
    localparam int DRAIN   = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        mode_lvl = 1'b1;
    logic        sw_rst = 1'b0;
    logic        wdt_ovf = 1'b0;
    logic        bidir_en = 1'b0;
    logic [15:0] cfg_in = 16'hA5C3;
    logic        int_rst, pin_pd_en, drain_req, cfg_stb;
    logic [15:0] cfg_q;
    logic [4:0]  rst_flags;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_cfg;

    always #2.5 clk = ~clk;

    rst_event_seq u0 (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .mode_lvl(mode_lvl),
        .sw_rst(sw_rst), .wdt_ovf(wdt_ovf), .bidir_en(bidir_en), .cfg_in(cfg_in),
        .int_rst(int_rst), .pin_pd_en(pin_pd_en), .drain_req(drain_req),
        .cfg_stb(cfg_stb), .cfg_q(cfg_q), .rst_flags(rst_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_power_on();
        int n;
        idle(3);
        check("R1 int_rst in reset", int_rst, 1);
        check("R1 flags in reset", rst_flags, 5'b00001);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (int_rst && n < 5000);
        check("R1 sequence end", n, SEQ);
        check("R1 cfg strobe", cfg_stb, 1);
        check("R1 cfg full latch", cfg_q, 16'hA5C3);
        check("R10 flags power-on", rst_flags, 5'b00001);
        exp_cfg = 16'hA5C3;
        idle(4);
    endtask

    task automatic t_glitch();
        logic [4:0] f0;
        int hits;
        f0 = rst_flags;
        hits = 0;
        cfg_in = 16'hFFFF;
        ext_rst_n = 1'b0;
        for (int k = 1; k <= MIN_W + 30; k++) begin
            @(negedge clk);
            if (k == MIN_W) ext_rst_n = 1'b1;
            if (int_rst || drain_req || cfg_stb) hits++;
        end
        check("R2 glitch ignored", hits, 0);
        check("R2 glitch flags kept", rst_flags, f0);
        check("R2 glitch cfg kept", cfg_q, exp_cfg);
    endtask

    task automatic t_pin(input int len, input logic bd, input logic [15:0] cin, input logic is_long);
        int first_d, ndrain, npd, nrst, fall_k, overlap, stb;
        logic seen;
        int exp_rst;
        first_d = 0; ndrain = 0; npd = 0; nrst = 0; fall_k = 0; overlap = 0; stb = 0;
        seen = 1'b0;
        bidir_en = bd;
        cfg_in = cin;
        ext_rst_n = 1'b0;
        for (int k = 1; k < 3000; k++) begin
            @(negedge clk);
            if (k == len) ext_rst_n = 1'b1;
            if (drain_req) begin
                ndrain++;
                if (first_d == 0) first_d = k;
                if (int_rst) overlap++;
            end
            if (pin_pd_en) npd++;
            if (int_rst) begin
                seen = 1'b1;
                nrst++;
            end else if (seen) begin
                stb = cfg_stb;
                fall_k = k;
                break;
            end
        end
        exp_rst = (len - MIN_W - 6 > SEQ) ? (len - MIN_W - 6) : SEQ;
        check("R2 drain onset", first_d, MIN_W + 3);
        check("R3 drain length", ndrain, DRAIN);
        check("R3 no reset during drain", overlap, 0);
        check("R4 reset length", nrst, exp_rst);
        if (exp_rst > SEQ) check("R4 release to fall", fall_k, len + 3);
        check("R8 pull-down length", npd, bd ? SEQ : 0);
        check("R6 strobe at fall", stb, 1);
        check("R5 class flags", rst_flags, is_long ? 5'b00010 : 5'b00100);
        if (is_long) exp_cfg = cin;
        else         exp_cfg = {exp_cfg[15:13], cin[12:0]};
        check("R6 cfg latch", cfg_q, exp_cfg);
        idle(4);
    endtask

    task automatic t_soft(input logic s, input logic w, input logic md, input logic bd);
        int npd, nrst, stb;
        npd = 0; nrst = 0; stb = 0;
        mode_lvl = md;
        bidir_en = bd;
        cfg_in = 16'h0F0F;
        sw_rst = s;
        wdt_ovf = w;
        for (int k = 1; k < 2000; k++) begin
            @(negedge clk);
            if (k == 1) begin
                sw_rst = 1'b0;
                wdt_ovf = 1'b0;
            end
            if (k == 3) begin
                sw_rst = 1'b1;
                wdt_ovf = 1'b1;
            end
            if (k == 4) begin
                sw_rst = 1'b0;
                wdt_ovf = 1'b0;
            end
            if (pin_pd_en) npd++;
            if (int_rst) nrst++;
            else begin
                stb = cfg_stb;
                break;
            end
        end
        check("R7 soft sequence length", nrst, SEQ);
        check("R8 soft pull-down", npd, (bd && md) ? SEQ : 0);
        check("R7 soft flags", rst_flags, w ? 5'b01000 : 5'b10000);
        check("R7 no cfg strobe", stb, 0);
        check("R7 cfg unchanged", cfg_q, exp_cfg);
        mode_lvl = 1'b1;
        idle(4);
    endtask

    task automatic t_async(input logic abort_sw);
        int npd, stb, pd_hold;
        npd = 0; stb = 0; pd_hold = 0;
        bidir_en = 1'b1;
        cfg_in = 16'h3C5A;
        if (abort_sw) begin
            sw_rst = 1'b1;
            @(negedge clk);
            sw_rst = 1'b0;
            idle(20);
            check("R9 soft sequence running", pin_pd_en, 1);
        end
        mode_lvl = 1'b0;
        ext_rst_n = 1'b0;
        #1;
        check("R9 immediate reset", int_rst, 1);
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (pin_pd_en || !int_rst) pd_hold++;
        end
        check("R9 held without pull-down", pd_hold, 0);
        ext_rst_n = 1'b1;
        for (int k = 1; k < 2000; k++) begin
            @(negedge clk);
            if (pin_pd_en) npd++;
            if (!int_rst) begin
                stb = cfg_stb;
                break;
            end
        end
        check("R8 async pull-down", npd, SEQ);
        check("R9 async flags", rst_flags, 5'b00001);
        check("R9 async strobe", stb, 1);
        exp_cfg = 16'h3C5A;
        check("R9 async cfg", cfg_q, exp_cfg);
        mode_lvl = 1'b1;
        idle(4);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_cfg = 16'h0;
        t_power_on();
        t_glitch();
        t_pin(MIN_W + 1, 1'b1, 16'h1234, 1'b0);
        t_pin(LONG_W, 1'b0, 16'h4321, 1'b0);
        t_pin(LONG_W + 1, 1'b1, 16'h6E01, 1'b1);
        t_soft(1'b1, 1'b0, 1'b1, 1'b1);
        t_soft(1'b0, 1'b1, 1'b0, 1'b1);
        t_soft(1'b1, 1'b1, 1'b1, 1'b0);
        t_async(1'b0);
        t_async(1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule